// File: doc/BRIEF.md
# Codec Clock Divider with Sync

This block derives every timing signal a converter front end needs from one master clock. A free-running phase counter drives four registered outputs. The first is a clock output at one eighth of the master rate. The second is a serial bit clock with the same waveform. The third is a host interrupt strobe that runs at one eighth or one sixteenth of the master rate, chosen by the oversample select. The fourth is a one-cycle keep-out flag that warns of the next clock-output edge, so that neighbouring logic can keep quiet while analog sampling happens.

Several devices driven from the same master clock stay in phase by sharing a synchronisation line. A rising edge on that line, seen at a master-clock edge, reloads the phase counter. The clock output and the interrupt then rise together on the fourth master-clock edge that follows. Reset puts the counter in the same state, so a freshly reset device and a freshly synchronised device have the same timing. When the sync line is held low, the phase simply runs free.

Top module: `codec_clkgen`

## Requirements
- R1: `clkout_o` has a period of DIV master cycles (default 8) with a 50% duty cycle. It goes high on the phase-0 edge and low DIV/2 edges later.
- R2: `sclk_o` runs continuously and has exactly the same waveform and edges as `clkout_o` (default polarity).
- R3: With the effective oversample setting at 0, `int_o` has a period of 2*DIV cycles (16) and is high for the first DIV cycles. With the setting at 1, it matches `clkout_o` (period 8). Every rising edge of `int_o` coincides with a rising edge of `clkout_o`.
- R4: A change on `os_sel_i` is adopted only at an edge where the phase returns to 0, that is, at an interrupt period boundary. Unless a sync cuts it short, every high or low run of `int_o` lasts at least DIV/2 cycles.
- R5: When `sync_i` is sampled high at edge E0 after being low at the previous edge, `clkout_o`, `sclk_o` and `int_o` are low after E0, E1, E2 and E3, and `clkout_o` and `int_o` both rise at E4.
- R6: `koz_o` is high during a cycle exactly when the next master-clock edge makes `clkout_o` change by free counting, which is the cycle before each such edge. It is low in all other cycles.
- R7: A `sync_i` held high for many cycles counts as a single event at its rising edge. While it stays high the outputs keep toggling with the normal periods.
- R8: While `rst_ni` is low, all four outputs are low. After release, `clkout_o` and `int_o` first rise on the fourth master-clock edge, the same phase as after a sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Phase realignment request, active on its rising edge |
| os_sel_i | input | 1 | Oversample select: 1 gives the fast interrupt rate, 0 the slow one |
| int_o | output | 1 | Host interrupt strobe |
| clkout_o | output | 1 | Clock output, master divided by DIV |
| sclk_o | output | 1 | Serial bit clock, aligned with clkout_o |
| koz_o | output | 1 | Keep-out flag, high in the cycle before a clkout_o edge |

## Verification
The bench counts master-clock edges from a sync or from reset release to the first rise. A design that reloads the counter off by one would rise on the third or fifth edge and fail that count.

A sync held high across many cycles is aimed at designs that reload on the level: those would freeze all outputs low for the whole pulse. The oversample select is toggled at random phases, and the bench measures the length of every interrupt run. Adopting the select mid-period would leave a short pulse on `int_o`.

The keep-out flag is compared in every cycle, so a flag placed one cycle late, or raised before both edges, shows up at once.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

   typedef struct packed {
      logic clkout;
      logic sclk;
      logic intr;
      logic koz;
   } ckdiv_out_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ckdiv_sync_edge.sv
module ckdiv_sync_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   output logic rise_o
);

   logic sync_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_prev_q <= 1'b0;
      else         sync_prev_q <= sync_i;
   end

   // Only the low-to-high step is an event; a held level is ignored.
   assign rise_o = sync_i & ~sync_prev_q;

   a_r7_single_event : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/ckdiv_phase_ctr.sv
module ckdiv_phase_ctr #(
   parameter int unsigned PERIOD    = 16,
   parameter int unsigned SYNC_LEAD = 4,
   localparam int unsigned CW       = $clog2(PERIOD)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cnt_nxt_o
);

   // Phase value that reaches 0 exactly SYNC_LEAD edges after a load.
   localparam logic [CW-1:0] LOAD_VAL = CW'(PERIOD - SYNC_LEAD);

   generate
      if (!ckdiv_pkg::is_pow2(PERIOD)) begin : g_bad_period
         $error("PERIOD must be a power of two");
      end
      if (SYNC_LEAD < 1 || SYNC_LEAD > PERIOD) begin : g_bad_lead
         $error("SYNC_LEAD must lie in 1..PERIOD");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign cnt_nxt_o = load_i ? LOAD_VAL : cnt_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= LOAD_VAL;
      else         cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;

   a_r5_reload : assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cnt_q == LOAD_VAL);

endmodule

// File: rtl/ckdiv_decode.sv
module ckdiv_decode
   import ckdiv_pkg::*;
#(
   parameter int unsigned DIV       = 8,
   parameter int unsigned SLOW_MULT = 2,
   parameter bit          SCLK_INV  = 1'b0,
   localparam int unsigned PERIOD   = DIV * SLOW_MULT,
   localparam int unsigned CW       = $clog2(PERIOD),
   localparam int unsigned DW       = $clog2(DIV)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_nxt_i,
   input  logic          os_sel_i,
   output ckdiv_out_t    out_o
);

   generate
      if (DIV < 4 || !is_pow2(DIV)) begin : g_bad_div
         $error("DIV must be a power of two of at least 4");
      end
      if (!is_pow2(SLOW_MULT)) begin : g_bad_mult
         $error("SLOW_MULT must be a power of two");
      end
   endgenerate

   logic os_eff_q, os_nxt;
   logic boundary;
   logic clk_d, slow_d, int_d, koz_d, sclk_d;

   assign boundary = (cnt_nxt_i == '0);
   assign os_nxt   = boundary ? os_sel_i : os_eff_q;

   assign clk_d  = ~cnt_nxt_i[DW-1];
   assign slow_d = ~cnt_nxt_i[CW-1];
   assign int_d  = os_nxt ? clk_d : slow_d;
   assign koz_d  = &cnt_nxt_i[DW-2:0];

   generate
      if (SCLK_INV) begin : g_sclk_inv
         assign sclk_d = ~clk_d;
      end else begin : g_sclk_true
         assign sclk_d = clk_d;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         os_eff_q <= 1'b0;
         out_o    <= '{clkout: 1'b0, sclk: SCLK_INV, intr: 1'b0, koz: 1'b0};
      end else begin
         os_eff_q <= os_nxt;
         out_o    <= '{clkout: clk_d, sclk: sclk_d, intr: int_d, koz: koz_d};
      end
   end

   a_r2_sclk_edges : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $changed(out_o.clkout) |-> $changed(out_o.sclk));

endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen #(
   parameter int unsigned DIV       = 8,
   parameter int unsigned SLOW_MULT = 2,
   parameter int unsigned SYNC_LEAD = 4,
   parameter bit          SCLK_INV  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   input  logic os_sel_i,
   output logic int_o,
   output logic clkout_o,
   output logic sclk_o,
   output logic koz_o
);
   import ckdiv_pkg::*;

   localparam int unsigned PERIOD = DIV * SLOW_MULT;
   localparam int unsigned CW     = $clog2(PERIOD);
   localparam int unsigned HALF   = DIV / 2;

   logic          sync_rise;
   logic [CW-1:0] cnt, cnt_nxt;
   ckdiv_out_t    outs;

   ckdiv_sync_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_i),
      .rise_o (sync_rise)
   );

   ckdiv_phase_ctr #(.PERIOD(PERIOD), .SYNC_LEAD(SYNC_LEAD)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (sync_rise),
      .cnt_o     (cnt),
      .cnt_nxt_o (cnt_nxt)
   );

   ckdiv_decode #(.DIV(DIV), .SLOW_MULT(SLOW_MULT), .SCLK_INV(SCLK_INV)) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_i (cnt_nxt),
      .os_sel_i  (os_sel_i),
      .out_o     (outs)
   );

   assign int_o    = outs.intr;
   assign clkout_o = outs.clkout;
   assign sclk_o   = outs.sclk;
   assign koz_o    = outs.koz;

   // Checker: length of the current high run of int_o.
   logic [CW:0] hrun_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                hrun_q <= '0;
      else if (!int_o)            hrun_q <= '0;
      else if (hrun_q != '1)      hrun_q <= hrun_q + 1'b1;
   end

   a_r6_koz_then_edge : assert property (@(posedge clk_i) disable iff (!rst_ni)
      koz_o && !sync_rise |=> clkout_o != $past(clkout_o));

   a_r6_quiet_without_koz : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !koz_o && !sync_rise |=> $stable(clkout_o));

   a_r5_sync_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_rise |=> !clkout_o && !int_o);

   a_r3_int_rises_with_clkout : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_o) |-> $rose(clkout_o));

   a_r4_no_runt : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(int_o) && !$past(sync_rise) |-> hrun_q >= (CW+1)'(HALF));

endmodule

// File: tb/codec_clkgen_bench.sv
module codec_clkgen_bench;

   localparam int P    = 16;
   localparam int LEAD = 4;

   logic clk = 1'b0;
   logic rst_n, sync_s, os_s;
   logic int_w, clkout_w, sclk_w, koz_w;

   always #4 clk = ~clk;

   codec_clkgen u_codec_clkgen (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .sync_i   (sync_s),
      .os_sel_i (os_s),
      .int_o    (int_w),
      .clkout_o (clkout_w),
      .sclk_o   (sclk_w),
      .koz_o    (koz_w)
   );

   int checks = 0;
   int errors = 0;

   // Model state: edges since the last anchor (reset release or sync rise).
   int m;
   bit prev_s;
   bit os_eff;
   int run_len;
   bit run_cut;
   bit last_int;

   function automatic int phase_of(input int edges);
      return (edges + P - LEAD) % P;
   endfunction

   function automatic bit exp_clk(input int ph);
      return (ph % 8) < 4;
   endfunction

   function automatic bit exp_int(input int ph, input bit os);
      return os ? exp_clk(ph) : (ph < 8);
   endfunction

   function automatic bit exp_koz(input int ph);
      return (ph % 4) == 3;
   endfunction

   task automatic chk(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      m = 0; prev_s = 1'b0; os_eff = 1'b0;
      run_len = 0; run_cut = 1'b1; last_int = 1'b0;
   endtask

   // One master cycle: drive, clock, model, then compare after the edge.
   task automatic cyc(input bit s, input bit o);
      int ph;
      sync_s = s; os_s = o;
      @(posedge clk);
      if (s && !prev_s) begin m = 0; run_cut = 1'b1; end
      else m++;
      prev_s = s;
      ph = phase_of(m);
      if (ph == 0) os_eff = o;
      @(negedge clk);
      chk(clkout_w, exp_clk(ph),         "R1 clkout");
      chk(sclk_w,   exp_clk(ph),         "R2 sclk");
      chk(int_w,    exp_int(ph, os_eff), "R3 int");
      chk(koz_w,    exp_koz(ph),         "R6 koz");
      // R4: runs of int_o shorter than 4 only when a sync cut them
      if (int_w != last_int) begin
         if (!run_cut) chk(run_len >= 4, 1'b1, "R4 int run length");
         run_len = 1; run_cut = 1'b0; last_int = int_w;
      end else run_len++;
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int left;
      bit s, o;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; sync_s = 1'b0; os_s = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      // R8: all outputs low in reset
      chk(clkout_w | sclk_w | int_w | koz_w, 1'b0, "R8 reset outputs");
      rst_n = 1'b1;

      // R8: first rise on the fourth edge after release
      for (int i = 0; i < 24; i++) begin
         cyc(1'b0, 1'b0);
         if (i < 3) chk(clkout_w | int_w, 1'b0, "R8 low before fourth edge");
         if (i == 3) chk(clkout_w & int_w, 1'b1, "R8 rise on fourth edge");
      end

      // R4: switch to fast interrupt rate mid-period
      for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1);
      for (int i = 0; i < 37; i++) cyc(1'b0, 1'b0);

      // R5: single-cycle sync pulse
      cyc(1'b1, 1'b1);
      chk(clkout_w | sclk_w | int_w, 1'b0, "R5 low after E0");
      for (int i = 1; i <= 4; i++) begin
         cyc(1'b0, 1'b1);
         if (i < 4) chk(clkout_w | sclk_w | int_w, 1'b0, "R5 low before E4");
         else       chk(clkout_w & int_w, 1'b1, "R5 rise at E4");
      end
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);

      // R7: sync held high is one event and does not freeze the outputs
      for (int i = 0; i < 14; i++) begin
         cyc(1'b1, 1'b0);
         if (i == 4)  chk(clkout_w, 1'b1, "R7 rise while held");
         if (i == 8)  chk(clkout_w, 1'b0, "R7 fall while held");
         if (i == 12) chk(clkout_w, 1'b1, "R7 next rise while held");
      end
      for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);

      // Random stimulus with sync pulses and select changes
      left = 0; o = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if (left == 0 && ($urandom % 40) == 0) left = 1 + ($urandom % 4);
         s = (left != 0);
         if (left != 0) left--;
         if (($urandom % 50) == 0) o = ~o;
         cyc(s, o);
      end

      // R8: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0; sync_s = 1'b0;
      #1;
      chk(clkout_w | sclk_w | int_w | koz_w, 1'b0, "R8 mid-run reset");
      @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
         cyc(1'b0, 1'b1);
         if (i == 3) chk(clkout_w & int_w, 1'b1, "R8 rise after second release");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule